// File: doc/BRIEF.md
# Multi-Channel Timer Unit

This block groups two or three down-counting timer channels behind a single 48-byte register window. Word accesses arrive on a simple strobe interface: `wr_en_i` writes `wdata_i` on the clock edge, and `rd_en_i` returns data on `rdata_o` in the same cycle, because the read path is purely combinational. A shared run register turns each channel on or off. A one-bit output-control register is present as a build option. Each channel has its own window, which holds a reload value, a live counter and a control word.

A channel that is running counts a prescaled version of the clock. When its counter reaches zero on a tick, the next tick reloads it from the reload value and sets an underflow flag. If the channel's interrupt enable is also set, the flag drives that channel's level interrupt. The build option that adds the third channel also gives that channel a plain read/write capture word.

Top module: `multi_timer_unit`

## Requirements
- R1: The word at byte offset 0x00 keeps only bit 0 of the written value and reads it back with all other bits 0. This applies only when `HAS_OUTCTL` is 1.
- R2: The word at 0x04 returns the full 32-bit value last written. Its bit i runs channel i, and 1 means running. Its reset value is 0.
- R3: Addresses are compared against the channel bases from the highest base down: 0x20 for channel 2, then 0x14 for channel 1, then 0x08 for channel 0. The channel receives the address minus its base. The local word offsets are: 0x0 reload value (reset 0xFFFFFFFF), 0x4 counter (reset 0xFFFFFFFF), 0x8 control (reset 0).
- R4: Only channel 2 has a capture word, at local offset 0xC (byte 0x2C). It is read/write and resets to 0. When `THREE_CH` is 0, byte 0x2C reads 0.
- R5: Control bits [2:0] select the tick period. Values 0 to 4 give 4, 16, 64, 256 and 1024 clocks. A write to the control word clears the prescaler. While the channel runs, the counter decrements once per tick, so it falls by floor(E/period) over E running clock edges that follow a control write.
- R6: A tick that finds the counter at 0 reloads it from the reload value and sets the underflow flag, which is read in control bit 8.
- R7: The channel interrupt equals the underflow flag AND control bit 5, the interrupt enable. Writing control with bit 8 at 0 clears the flag. Writing it with bit 8 at 1 leaves the flag unchanged.
- R8: Clearing a run bit freezes the counter and its prescaler. Setting the bit again resumes counting from the frozen state.
- R9: Undecoded addresses read 0 and ignore writes. These are 0x00 without `HAS_OUTCTL`, 0x20 to 0x3F without `THREE_CH`, and 0x30 to 0x3F in every build.
- R10: Tick selections 5, 6 and 7 produce no ticks, so the counter holds even while the channel runs.
- R11: When `THREE_CH` is 0, run bit 2 has no effect and the channel 2 interrupt stays 0. The run bit still reads back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe; `rdata_o` is 0 when low |
| addr_i | input | 6 | Byte address within the window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data |
| irq_o | output | 3 | Level interrupt per channel |

## Verification
The bench builds two copies of the block, and both see the same bus. One copy has the defaults `THREE_CH=1, HAS_OUTCTL=1`. The other has both options at 0. Comparing their read data for the same accesses exposes the address holes, the ignored run bit and the missing capture word, which the full build cannot show. Counting, reload, flag and interrupt behaviour is exercised in all three channels of the full build, with cycle-exact expected counts for the 4-clock and 16-clock tick periods.

// File: rtl/tmu_pkg.sv
package tmu_pkg;
  localparam int ADDR_W   = 6;
  localparam int WADDR_W  = ADDR_W - 2;
  localparam int DATA_W   = 32;
  localparam int MAX_CH   = 3;
  localparam int SEL_W    = 3;
  localparam int NUM_DIV  = 5;
  localparam int PRE_W    = 2 + 2 * (NUM_DIV - 1);
  localparam int IE_BIT   = 5;
  localparam int UF_BIT   = 8;

  typedef enum logic [1:0] {
    REG_RELOAD = 2'd0,
    REG_COUNT  = 2'd1,
    REG_CTRL   = 2'd2,
    REG_CAPT   = 2'd3
  } chreg_e;

  // terminal prescaler value for a tick selection (period 4^(sel+1))
  function automatic logic [PRE_W-1:0] div_limit(input logic [SEL_W-1:0] sel);
    logic [PRE_W+1:0] v;
    v = (PRE_W+2)'(1) << (2 + 2 * int'(sel));
    v = v - 1'b1;
    return v[PRE_W-1:0];
  endfunction
endpackage

// File: rtl/tmu_prescaler.sv
module tmu_prescaler
  import tmu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             clr_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] cnt_q, cnt_d;
  logic             sel_ok, at_lim, cnt_en;

  always_comb begin
    sel_ok = (sel_i < SEL_W'(NUM_DIV));
    at_lim = (cnt_q == div_limit(sel_i));
    cnt_en = clr_i || (run_i && sel_ok);
    tick_o = run_i && sel_ok && at_lim && !clr_i;
    cnt_d  = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (at_lim) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  // R8: a stopped prescaler holds its phase unless cleared by a control write
  assert_prescale_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !clr_i) |=> $stable(cnt_q));
endmodule

// File: rtl/tmu_channel.sv
module tmu_channel
  import tmu_pkg::*;
#(
  parameter bit HAS_CAPT = 1'b0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run_i,
  input  logic               wr_i,
  input  logic [WADDR_W-1:0] word_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o
);
  logic              in_win;
  chreg_e            reg_idx;
  logic              wr_reload, wr_count, wr_ctrl, wr_capt;
  logic              tick, uf_evt;
  logic [DATA_W-1:0] reload_q, reload_d, count_q, count_d;
  logic [SEL_W-1:0]  sel_q, sel_d;
  logic              ie_q, ie_d, flag_q, flag_d;
  logic [DATA_W-1:0] capt_val;

  always_comb begin
    in_win    = (word_i[WADDR_W-1:2] == '0);
    reg_idx   = chreg_e'(word_i[1:0]);
    wr_reload = wr_i && in_win && (reg_idx == REG_RELOAD);
    wr_count  = wr_i && in_win && (reg_idx == REG_COUNT);
    wr_ctrl   = wr_i && in_win && (reg_idx == REG_CTRL);
    wr_capt   = wr_i && in_win && (reg_idx == REG_CAPT) && HAS_CAPT;
  end

  tmu_prescaler u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run_i),
    .clr_i  (wr_ctrl),
    .sel_i  (sel_q),
    .tick_o (tick)
  );

  // next-state logic
  always_comb begin
    uf_evt   = tick && (count_q == '0);
    reload_d = wr_reload ? wdata_i : reload_q;
    count_d  = count_q;
    if (wr_count)    count_d = wdata_i;
    else if (uf_evt) count_d = reload_q;
    else if (tick)   count_d = count_q - 1'b1;
    sel_d  = wr_ctrl ? wdata_i[SEL_W-1:0] : sel_q;
    ie_d   = wr_ctrl ? wdata_i[IE_BIT] : ie_q;
    flag_d = flag_q;
    if (wr_ctrl && !wdata_i[UF_BIT]) flag_d = 1'b0;
    if (uf_evt)                      flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reload_q <= '1;
      count_q  <= '1;
      sel_q    <= '0;
      ie_q     <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      if (wr_reload)        reload_q <= reload_d;
      if (wr_count || tick) count_q  <= count_d;
      if (wr_ctrl) begin
        sel_q <= sel_d;
        ie_q  <= ie_d;
      end
      if (wr_ctrl || uf_evt) flag_q <= flag_d;
    end
  end

  generate
    if (HAS_CAPT) begin : g_capt
      logic [DATA_W-1:0] capt_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       capt_q <= '0;
        else if (wr_capt) capt_q <= wdata_i;
      end
      assign capt_val = capt_q;
    end else begin : g_no_capt
      assign capt_val = '0;
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    if (in_win) begin
      unique case (reg_idx)
        REG_RELOAD: rdata_o = reload_q;
        REG_COUNT:  rdata_o = count_q;
        REG_CTRL: begin
          rdata_o[SEL_W-1:0] = sel_q;
          rdata_o[IE_BIT]    = ie_q;
          rdata_o[UF_BIT]    = flag_q;
        end
        REG_CAPT:   rdata_o = capt_val;
      endcase
    end
  end

  assign irq_o = flag_q & ie_q;

  // R8: no run and no write leaves the counter unchanged
  assert_count_frozen_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!run_i && !wr_count) |=> $stable(count_q));
  // R6: the flag only rises after a prescaler tick
  assert_flag_from_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag_q) |-> $past(tick));
  // R6: a tick at zero reloads the counter
  assert_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && count_q == '0 && !wr_count) |=> (count_q == $past(reload_q)));
endmodule

// File: rtl/tmu_addr_decode.sv
module tmu_addr_decode
  import tmu_pkg::*;
#(
  parameter int NCH        = 3,
  parameter bit HAS_OUTCTL = 1'b1
) (
  input  logic [WADDR_W-1:0] waddr_i,
  output logic               hit_outctl_o,
  output logic               hit_start_o,
  output logic [MAX_CH-1:0]  ch_hit_o,
  output logic [WADDR_W-1:0] word_o,
  output logic               hole_o
);
  // channel bases as word indices: bytes 0x08, 0x14, 0x20
  localparam logic [WADDR_W-1:0] CH_BASE [MAX_CH] =
    '{WADDR_W'(2), WADDR_W'(5), WADDR_W'(8)};

  logic found;

  always_comb begin
    found        = 1'b0;
    ch_hit_o     = '0;
    word_o       = '0;
    hit_outctl_o = 1'b0;
    hit_start_o  = 1'b0;
    for (int i = MAX_CH - 1; i >= 0; i--) begin
      if (!found && waddr_i >= CH_BASE[i]) begin
        found       = 1'b1;
        ch_hit_o[i] = (i < NCH);
        word_o      = waddr_i - CH_BASE[i];
      end
    end
    if (!found) begin
      hit_start_o  = (waddr_i == WADDR_W'(1));
      hit_outctl_o = (waddr_i == WADDR_W'(0)) && HAS_OUTCTL;
    end
    hole_o = !(hit_outctl_o || hit_start_o || (|ch_hit_o));
  end
endmodule

// File: rtl/multi_timer_unit.sv
module multi_timer_unit
  import tmu_pkg::*;
#(
  parameter bit THREE_CH   = 1'b1,
  parameter bit HAS_OUTCTL = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [MAX_CH-1:0] irq_o
);
  localparam int NCH = THREE_CH ? 3 : 2;

  logic rst_meta_q, rst_sync_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic               hit_outctl, hit_start, hole;
  logic [MAX_CH-1:0]  ch_hit;
  logic [WADDR_W-1:0] loc_word;
  logic [1:0]         byte_lane_unused;
  assign byte_lane_unused = addr_i[1:0];

  tmu_addr_decode #(.NCH(NCH), .HAS_OUTCTL(HAS_OUTCTL)) u_dec (
    .waddr_i      (addr_i[ADDR_W-1:2]),
    .hit_outctl_o (hit_outctl),
    .hit_start_o  (hit_start),
    .ch_hit_o     (ch_hit),
    .word_o       (loc_word),
    .hole_o       (hole)
  );

  logic [DATA_W-1:0] start_q, start_d;
  logic              outctl_q, outctl_d;
  logic              wr_start, wr_outctl;

  always_comb begin
    wr_start  = wr_en_i && hit_start;
    wr_outctl = wr_en_i && hit_outctl;
    start_d   = wdata_i;
    outctl_d  = wdata_i[0];
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      start_q  <= '0;
      outctl_q <= 1'b0;
    end else begin
      if (wr_start)  start_q  <= start_d;
      if (wr_outctl) outctl_q <= outctl_d;
    end
  end

  logic [DATA_W-1:0] ch_rdata [MAX_CH];

  generate
    for (genvar g = 0; g < MAX_CH; g++) begin : g_ch
      if (g < NCH) begin : g_on
        tmu_channel #(.HAS_CAPT(g == MAX_CH - 1)) u_ch (
          .clk     (clk),
          .rst_n   (rst_sync_q),
          .run_i   (start_q[g]),
          .wr_i    (wr_en_i && ch_hit[g]),
          .word_i  (loc_word),
          .wdata_i (wdata_i),
          .rdata_o (ch_rdata[g]),
          .irq_o   (irq_o[g])
        );
      end else begin : g_off
        assign ch_rdata[g] = '0;
        assign irq_o[g]    = 1'b0;
      end
    end
  endgenerate

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      if (hit_start)  rdata_o = start_q;
      if (hit_outctl) rdata_o = {{(DATA_W-1){1'b0}}, outctl_q};
      for (int i = 0; i < MAX_CH; i++)
        if (ch_hit[i]) rdata_o = ch_rdata[i];
    end
  end

  // R2: a run-register write stores the full word
  assert_start_store_R2: assert property (@(posedge clk) disable iff (!rst_sync_q)
    wr_start |=> (start_q == $past(wdata_i)));
  // R1: the output-control bit changes only through its own write
  assert_outctl_hold_R1: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !wr_outctl |=> $stable(outctl_q));
  // R9: an undecoded read returns zero
  assert_hole_read_R9: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (rd_en_i && hole) |-> (rdata_o == '0));
endmodule

// File: tb/multi_timer_unit_bench.sv
module multi_timer_unit_bench;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en;
  logic [5:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata_f, rdata_l;
  logic [2:0]  irq_f, irq_l;
  int          total = 0;
  int          bad = 0;
  logic [31:0] rf, rl;

  always #2.5 clk = ~clk;

  multi_timer_unit u_multi_timer_unit (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_f), .irq_o(irq_f));

  multi_timer_unit #(.THREE_CH(1'b0), .HAS_OUTCTL(1'b0)) u_multi_timer_unit_lite (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata_l), .irq_o(irq_l));

  function automatic logic [31:0] exp_count(int n, int c, int t);
    if (t <= n) return 32'(n - t);
    return 32'(c - ((t - n - 1) % (c + 1)));
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic bw(logic [5:0] a, logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic br(logic [5:0] a);
    addr = a; rd_en = 1'b1;
    #1;
    rf = rdata_f; rl = rdata_l;
    rd_en = 1'b0;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [5:0]  base;
    int n, c, s, e, t, ch;
    void'($urandom(32'd4242));
    rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    br(6'h04); chk("R2 reset run reg", rf, 32'h0);
    br(6'h00); chk("R1 reset outctl", rf, 32'h0);
    br(6'h08); chk("R3 reset reload", rf, 32'hFFFF_FFFF);
    br(6'h0C); chk("R3 reset counter", rf, 32'hFFFF_FFFF);
    br(6'h10); chk("R3 reset control", rf, 32'h0);
    br(6'h2C); chk("R4 reset capture", rf, 32'h0);
    chk("R7 reset irq", {29'd0, irq_f}, 32'h0);

    // R1 / R9 output control
    bw(6'h00, 32'hFFFF_FFFF);
    br(6'h00); chk("R1 outctl keeps bit0", rf, 32'h1);
    chk("R9 lite outctl hole", rl, 32'h0);
    bw(6'h00, 32'h2);
    br(6'h00); chk("R1 outctl bit0 clear", rf, 32'h0);

    // R2 run register readback (low bits kept zero)
    for (int i = 0; i < 4; i++) begin
      v = $urandom() & 32'hFFFF_FFF8;
      bw(6'h04, v);
      br(6'h04); chk("R2 run reg readback", rf, v);
      chk("R11 lite run reg readback", rl, v);
    end
    bw(6'h04, 32'h0);

    // R3 channel windows
    bw(6'h08, 32'h1111_0001);
    bw(6'h14, 32'h2222_0002);
    bw(6'h20, 32'h3333_0003);
    bw(6'h18, 32'h4444_0004);
    br(6'h08); chk("R3 ch0 reload", rf, 32'h1111_0001);
    br(6'h14); chk("R3 ch1 reload", rf, 32'h2222_0002);
    br(6'h20); chk("R3 ch2 reload", rf, 32'h3333_0003);
    chk("R9 lite ch2 absent", rl, 32'h0);
    br(6'h18); chk("R3 ch1 counter", rf, 32'h4444_0004);

    // R4 capture word
    bw(6'h2C, 32'hCAFE_0123);
    br(6'h2C); chk("R4 capture rw", rf, 32'hCAFE_0123);
    chk("R4 lite capture absent", rl, 32'h0);

    // R9 top holes
    bw(6'h30, 32'h5A5A_5A5A);
    br(6'h30); chk("R9 hole 0x30", rf, 32'h0);
    br(6'h3C); chk("R9 hole 0x3C", rf, 32'h0);

    // R11 lite: run bit 2 has no effect
    bw(6'h24, 32'h0);
    bw(6'h28, 32'h0000_0020);
    bw(6'h20, 32'h0);
    bw(6'h04, 32'h4);
    repeat (20) @(negedge clk);
    chk("R11 lite irq2 stays low", {31'd0, irq_l[2]}, 32'h0);
    br(6'h24); chk("R11 lite ch2 counter reads 0", rl, 32'h0);
    chk("R6 full ch2 underflow irq", {31'd0, irq_f[2]}, 32'h1);
    bw(6'h04, 32'h0);
    bw(6'h28, 32'h0);

    // R5 / R8 / R6 / R7 channel 0, period 4
    bw(6'h10, 32'h20);
    bw(6'h08, 32'd2);
    bw(6'h0C, 32'd5);
    bw(6'h04, 32'h1);
    repeat (9) @(negedge clk);
    bw(6'h04, 32'h0);
    br(6'h0C); chk("R5 count after 10 edges", rf, 32'd3);
    chk("R7 no irq before underflow", {31'd0, irq_f[0]}, 32'h0);
    repeat (7) @(negedge clk);
    br(6'h0C); chk("R8 frozen while stopped", rf, 32'd3);
    bw(6'h04, 32'h1);
    repeat (13) @(negedge clk);
    bw(6'h04, 32'h0);
    br(6'h0C); chk("R8 resume and R6 reload", rf, exp_count(5, 2, 6));
    chk("R7 irq on underflow", {31'd0, irq_f[0]}, 32'h1);
    br(6'h10); chk("R6 flag in control", rf, 32'h120);
    bw(6'h10, 32'h20);
    chk("R7 flag clear drops irq", {31'd0, irq_f[0]}, 32'h0);
    br(6'h10); chk("R7 control after clear", rf, 32'h20);

    // R6 / R7 channel 1, period 16, interrupt disabled
    bw(6'h1C, 32'h1);
    bw(6'h14, 32'd7);
    bw(6'h18, 32'd0);
    bw(6'h04, 32'h2);
    repeat (15) @(negedge clk);
    bw(6'h04, 32'h0);
    br(6'h18); chk("R6 ch1 reload from zero", rf, 32'd7);
    br(6'h1C); chk("R6 ch1 flag set", rf, 32'h101);
    chk("R7 irq masked", {31'd0, irq_f[1]}, 32'h0);
    bw(6'h1C, 32'h121);
    chk("R7 bit8 write keeps flag", {31'd0, irq_f[1]}, 32'h1);

    // R10 reserved tick selection
    bw(6'h10, 32'h5);
    bw(6'h0C, 32'd9);
    bw(6'h04, 32'h1);
    repeat (39) @(negedge clk);
    bw(6'h04, 32'h0);
    br(6'h0C); chk("R10 reserved select holds", rf, 32'd9);

    // constrained random counting runs (R5, R6, R7)
    for (int it = 0; it < 30; it++) begin
      ch = int'($urandom() % 3);
      base = (ch == 0) ? 6'h08 : (ch == 1) ? 6'h14 : 6'h20;
      n = int'($urandom() % 20);
      c = int'($urandom() % 10);
      s = int'($urandom() % 2);
      e = 1 + int'($urandom() % 150);
      bw(base + 6'h8, 32'(s) | 32'h20);
      bw(base, 32'(c));
      bw(base + 6'h4, 32'(n));
      bw(6'h04, 32'(1 << ch));
      repeat (e - 1) @(negedge clk);
      bw(6'h04, 32'h0);
      t = e / (s != 0 ? 16 : 4);
      br(base + 6'h4); chk("R5 random count", rf, exp_count(n, c, t));
      chk("R7 random irq", {31'd0, irq_f[ch]}, {31'd0, t > n});
    end

    finish_run();
  end
endmodule